// File: doc/BRIEF.md
# Serial Memory Command Front-End (1 kbit, byte or word organised)

This block is the slave side of a three-wire serial memory of 1 kbit. It oversamples the select, clock and data lines on a fast system clock. It recognises the start bit and collects the two-bit operation field, the address and any write data. It decodes the seven operations. The storage array is held inside the block, so the block answers read operations itself, including sequential streaming. Every other operation goes out to a separate programming controller as a one-cycle strobe on the select falling edge. The strobe carries the decoded kind, the address, the data and the number of serial clock pulses received.

The organisation pin picks the array view while the block runs. Low gives 128 bytes with 7-bit addresses. High gives 64 sixteen-bit words with 6-bit addresses. The programming controller changes the array through a plain write port. That port uses the same organisation view. Timing of programming, write protection and the pulse-count policy belong to the controller.

Top module: `uwire_mem_front`

## Requirements
- R1: After reset, `sdo_oe_o` and `cmd_valid_o` are low and every array location reads as ones (8'hFF per byte, 16'hFFFF per word).
- R2: An operation is armed only when select rises while the serial clock is low. Zeros sampled before the first '1' are skipped, and that first '1' is the start bit. If select rises while the serial clock is high, the whole selection is ignored: no output enable and no strobe.
- R3: The two bits after the start bit are the operation: 10 read, 01 write, 11 erase, 00 extended. For 00, the two top address bits pick unlock (11), lock (00), erase-all (10) or write-all (01). `cmd_kind_o` codes are 1 write, 2 erase, 3 erase-all, 4 write-all, 5 unlock, 6 lock.
- R4: `org_i` is sampled at the start bit. 0 means 7 address bits and 8 data bits. 1 means 6 address bits and 16 data bits. Fields arrive MSB first on serial clock rising edges, and `cmd_addr_o` / `cmd_data_o` are right-aligned.
- R5: When select falls after a non-read operation has received its full address, `cmd_valid_o` pulses for one cycle with kind, address, data and `cmd_wide_o`. Read operations never strobe.
- R6: `cmd_clks_o` counts the serial clock rising edges from the start bit (inclusive) to the select fall, saturating at 63. A complete byte write gives 18 and a word write gives 25. Surplus pulses are counted.
- R7: On the rising edge that samples the last address bit of a read, `sdo_oe_o` goes high with `sdo_o` = 0 (dummy bit). Each later rising edge presents the next data bit, MSB first.
- R8: While select stays high, reading continues at the next address with no dummy bit. It wraps from the highest address (127 bytes, 63 words) to 0.
- R9: `sdo_oe_o` is low outside a read's output phase and drops when select falls.
- R10: A pulse on `mem_we_i` writes `mem_wdata_i` at `mem_addr_i` in the current organisation. In byte mode it writes byte a with bits 7:0. In word mode word a sets byte 2a to bits 7:0 and byte 2a+1 to bits 15:8. Reads observe this mapping.
- R11: If a select fall and a serial clock rise reach the block in the same system cycle, the select fall wins: that pulse is neither sampled nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation: 0 byte, 1 word |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data out driver |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_kind_o | output | 3 | Decoded operation kind |
| cmd_addr_o | output | 7 | Received address, right-aligned |
| cmd_data_o | output | 16 | Received data, right-aligned |
| cmd_wide_o | output | 1 | Organisation in force for the command |
| cmd_clks_o | output | 6 | Serial clock pulses from start bit to select fall |
| mem_we_i | input | 1 | Array write strobe from the programming controller |
| mem_addr_i | input | 7 | Array write address |
| mem_wdata_i | input | 16 | Array write data |

## Verification
Two events can land in the same system cycle: the select fall that ends a command and a serial clock rise. Both arrive through synchronisers of equal depth, so they meet at the decoder together. The bench drives both pins at the same instant after a complete write operation. It then checks that the strobe still fires and that the reported pulse count leaves out the colliding pulse. Random byte and word traffic with surplus pulses shows whether the count and decode stay correct around that collision.

// File: rtl/uw_pkg.sv
package uw_pkg;

    typedef enum logic [2:0] {
        K_READ   = 3'd0,
        K_WR     = 3'd1,
        K_ER     = 3'd2,
        K_ERALL  = 3'd3,
        K_WRALL  = 3'd4,
        K_UNLOCK = 3'd5,
        K_LOCK   = 3'd6
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_TAIL,
        ST_READ,
        ST_SKIP
    } st_e;

endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/uw_array.sv
module uw_array #(
    parameter int BYTES = 128,
    parameter int BW    = 8,
    localparam int AW   = $clog2(BYTES),
    localparam int DW   = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_wide_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_wide_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [BW-1:0] mem_d [BYTES];
    logic [BW-1:0] mem_q [BYTES];

    always_comb begin
        for (int i = 0; i < BYTES; i++) mem_d[i] = mem_q[i];
        if (we_i) begin
            if (wr_wide_i) begin
                mem_d[{waddr_i[AW-2:0], 1'b0}] = wdata_i[BW-1:0];
                mem_d[{waddr_i[AW-2:0], 1'b1}] = wdata_i[DW-1:BW];
            end else begin
                mem_d[waddr_i] = wdata_i[BW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= mem_d[i];
        end
    end

    // Left-aligned read data: the word view places byte 2a+1 on top.
    always_comb begin
        if (rd_wide_i) rdata_o = {mem_q[{raddr_i[AW-2:0], 1'b1}], mem_q[{raddr_i[AW-2:0], 1'b0}]};
        else           rdata_o = {mem_q[raddr_i], {BW{1'b0}}};
    end

    // R10
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wr_wide_i && !rd_wide_i) ##1 (raddr_i == $past(waddr_i))
            |-> rdata_o[DW-1:BW] == $past(wdata_i[BW-1:0]));
endmodule

// File: rtl/uw_cmd.sv
module uw_cmd
    import uw_pkg::*;
#(
    parameter int AW  = 7,
    parameter int DW  = 16,
    parameter int CW  = 6,
    localparam int BCW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic          org_s,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          rd_wide_o,
    output logic          sdo_o,
    output logic          sdo_oe_o,
    output logic          cmd_valid_o,
    output logic [2:0]    cmd_kind_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic [DW-1:0] cmd_data_o,
    output logic          cmd_wide_o,
    output logic [CW-1:0] cmd_clks_o
);
    typedef struct packed {
        st_e            st;
        logic           cs_p;
        logic           sck_p;
        logic           wide;
        logic [1:0]     opc;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [BCW-1:0] bits;
        logic [CW-1:0]  clks;
        kind_e          kind;
        logic [DW-1:0]  obuf;
        logic [BCW-1:0] rem;
        logic           sdo;
        logic           oe;
        logic           vld;
    } cmd_t;

    cmd_t q, n;

    logic           rise, cs_rise, cs_fall;
    logic [BCW-1:0] alen, dlen;
    logic [AW-1:0]  amask, addr_sh;
    logic [1:0]     ext;

    always_comb begin
        n       = q;
        n.vld   = 1'b0;
        n.cs_p  = cs_s;
        n.sck_p = sck_s;

        rise    = sck_s & ~q.sck_p;
        cs_rise = cs_s & ~q.cs_p;
        cs_fall = ~cs_s & q.cs_p;

        alen    = q.wide ? BCW'(AW - 1) : BCW'(AW);
        dlen    = q.wide ? BCW'(DW) : BCW'(DW / 2);
        amask   = q.wide ? {1'b0, {(AW-1){1'b1}}} : {AW{1'b1}};
        addr_sh = {q.addr[AW-2:0], sdi_s};
        ext     = q.wide ? addr_sh[AW-2:AW-3] : addr_sh[AW-1:AW-2];

        if (cs_fall) begin
            if (q.st == ST_DATA || q.st == ST_TAIL) n.vld = 1'b1;
            n.st  = ST_IDLE;
            n.oe  = 1'b0;
            n.sdo = 1'b0;
        end else if (cs_rise) begin
            n.st = sck_s ? ST_SKIP : ST_START;
        end else if (rise) begin
            if (q.st inside {ST_OPC, ST_ADDR, ST_DATA, ST_TAIL, ST_READ} && q.clks != '1)
                n.clks = q.clks + 1'b1;
            case (q.st)
                ST_START: begin
                    if (sdi_s) begin
                        n.st   = ST_OPC;
                        n.clks = CW'(1);
                        n.bits = '0;
                        n.wide = org_s;
                        n.addr = '0;
                        n.data = '0;
                        n.opc  = '0;
                    end
                end
                ST_OPC: begin
                    n.opc  = {q.opc[0], sdi_s};
                    n.bits = q.bits + 1'b1;
                    if (q.bits == BCW'(1)) begin
                        n.st   = ST_ADDR;
                        n.bits = '0;
                    end
                end
                ST_ADDR: begin
                    n.addr = addr_sh;
                    n.bits = q.bits + 1'b1;
                    if (q.bits == alen - 1'b1) begin
                        n.bits = '0;
                        case (q.opc)
                            2'b10: begin
                                n.kind = K_READ;
                                n.st   = ST_READ;
                                n.oe   = 1'b1;
                                n.sdo  = 1'b0;
                                n.rem  = '0;
                            end
                            2'b01: begin n.kind = K_WR; n.st = ST_DATA; end
                            2'b11: begin n.kind = K_ER; n.st = ST_TAIL; end
                            default: begin
                                case (ext)
                                    2'b11:   begin n.kind = K_UNLOCK; n.st = ST_TAIL; end
                                    2'b00:   begin n.kind = K_LOCK;   n.st = ST_TAIL; end
                                    2'b10:   begin n.kind = K_ERALL;  n.st = ST_TAIL; end
                                    default: begin n.kind = K_WRALL;  n.st = ST_DATA; end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    n.data = {q.data[DW-2:0], sdi_s};
                    n.bits = q.bits + 1'b1;
                    if (q.bits == dlen - 1'b1) n.st = ST_TAIL;
                end
                ST_READ: begin
                    if (q.rem == '0) begin
                        n.sdo  = rd_data_i[DW-1];
                        n.obuf = rd_data_i << 1;
                        n.rem  = dlen - 1'b1;
                        n.addr = AW'(q.addr + 1'b1) & amask;
                    end else begin
                        n.sdo  = q.obuf[DW-1];
                        n.obuf = q.obuf << 1;
                        n.rem  = q.rem - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rd_addr_o   = q.addr;
    assign rd_wide_o   = q.wide;
    assign sdo_o       = q.sdo;
    assign sdo_oe_o    = q.oe;
    assign cmd_valid_o = q.vld;
    assign cmd_kind_o  = q.kind;
    assign cmd_addr_o  = q.addr;
    assign cmd_data_o  = q.data;
    assign cmd_wide_o  = q.wide;
    assign cmd_clks_o  = q.clks;

    // R9
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !sdo_oe_o);

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R5
    strobe_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (q.kind != K_READ) && !cs_s);

    // R6
    strobe_clks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_clks_o >= CW'(AW + 2));

    // R8
    word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ && q.wide) |-> !q.addr[AW-1]);

    // R7
    dummy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> !sdo_o && q.kind == K_READ);
endmodule

// File: rtl/uwire_mem_front.sv
module uwire_mem_front #(
    parameter int BYTES = 128,
    parameter int CW    = 6,
    localparam int AW   = $clog2(BYTES),
    localparam int BW   = 8,
    localparam int DW   = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          sck_i,
    input  logic          sdi_i,
    input  logic          org_i,
    output logic          sdo_o,
    output logic          sdo_oe_o,
    output logic          cmd_valid_o,
    output logic [2:0]    cmd_kind_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic [DW-1:0] cmd_data_o,
    output logic          cmd_wide_o,
    output logic [CW-1:0] cmd_clks_o,
    input  logic          mem_we_i,
    input  logic [AW-1:0] mem_addr_i,
    input  logic [DW-1:0] mem_wdata_i
);
    logic [3:0]    pins_s;
    logic [AW-1:0] rd_addr;
    logic          rd_wide;
    logic [DW-1:0] rd_data;

    uw_sync #(.W(4), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({org_i, sdi_i, sck_i, cs_i}),
        .q_o   (pins_s)
    );

    uw_array #(.BYTES(BYTES), .BW(BW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_wide_i (pins_s[3]),
        .we_i      (mem_we_i),
        .waddr_i   (mem_addr_i),
        .wdata_i   (mem_wdata_i),
        .rd_wide_i (rd_wide),
        .raddr_i   (rd_addr),
        .rdata_o   (rd_data)
    );

    uw_cmd #(.AW(AW), .DW(DW), .CW(CW)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (pins_s[0]),
        .sck_s       (pins_s[1]),
        .sdi_s       (pins_s[2]),
        .org_s       (pins_s[3]),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .rd_wide_o   (rd_wide),
        .sdo_o       (sdo_o),
        .sdo_oe_o    (sdo_oe_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_kind_o  (cmd_kind_o),
        .cmd_addr_o  (cmd_addr_o),
        .cmd_data_o  (cmd_data_o),
        .cmd_wide_o  (cmd_wide_o),
        .cmd_clks_o  (cmd_clks_o)
    );
endmodule

// File: tb/uwire_mem_front_test.sv
module uwire_mem_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 0, sck_i = 0, sdi_i = 0, org_i = 0;
    logic sdo_o, sdo_oe_o, cmd_valid_o, cmd_wide_o;
    logic [2:0] cmd_kind_o;
    logic [6:0] cmd_addr_o;
    logic [15:0] cmd_data_o;
    logic [5:0] cmd_clks_o;
    logic mem_we_i = 0;
    logic [6:0] mem_addr_i = 0;
    logic [15:0] mem_wdata_i = 0;

    int total = 0, bad = 0;
    int cap_n = 0;
    logic [2:0] cap_kind;
    logic [6:0] cap_addr;
    logic [15:0] cap_data;
    logic [5:0] cap_clks;
    logic [7:0] bm [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    uwire_mem_front uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sck_i(sck_i), .sdi_i(sdi_i),
        .org_i(org_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .cmd_valid_o(cmd_valid_o), .cmd_kind_o(cmd_kind_o), .cmd_addr_o(cmd_addr_o),
        .cmd_data_o(cmd_data_o), .cmd_wide_o(cmd_wide_o), .cmd_clks_o(cmd_clks_o),
        .mem_we_i(mem_we_i), .mem_addr_i(mem_addr_i), .mem_wdata_i(mem_wdata_i)
    );

    always @(negedge clk) begin
        if (cmd_valid_o) begin
            cap_n    <= cap_n + 1;
            cap_kind <= cmd_kind_o;
            cap_addr <= cmd_addr_o;
            cap_data <= cmd_data_o;
            cap_clks <= cmd_clks_o;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic d, output logic so, output logic oe);
        sdi_i = d;
        tick(H);
        so = sdo_o;
        oe = sdo_oe_o;
        sck_i = 1'b1;
        tick(H);
        sck_i = 1'b0;
    endtask

    task automatic set_org(input logic w);
        if (org_i !== w) begin
            org_i = w;
            tick(6);
        end
    endtask

    function automatic logic [15:0] exp_word(input int a, input logic w);
        return w ? {bm[2*a+1], bm[2*a]} : {8'h00, bm[a]};
    endfunction

    function automatic int exp_kind(input logic [1:0] op, input int a, input logic w);
        int top;
        top = w ? (a >> 4) & 3 : (a >> 5) & 3;
        case (op)
            2'b01: return 1;
            2'b11: return 2;
            2'b10: return 0;
            default: case (top)
                3: return 5;
                0: return 6;
                2: return 3;
                default: return 4;
            endcase
        endcase
    endfunction

    task automatic mwrite(input logic w, input int a, input logic [15:0] d);
        set_org(w);
        mem_we_i = 1'b1;
        mem_addr_i = 7'(a);
        mem_wdata_i = d;
        tick(1);
        mem_we_i = 1'b0;
        if (w) begin
            bm[2*a] = d[7:0];
            bm[2*a+1] = d[15:8];
        end else begin
            bm[a] = d[7:0];
        end
    endtask

    task automatic do_read(input logic w, input int a, input int nw, input int lead);
        logic so, oe;
        logic [15:0] got;
        int alen, dlen, ad, n0;
        alen = w ? 6 : 7;
        dlen = w ? 16 : 8;
        n0 = cap_n;
        set_org(w);
        cs_i = 1'b1;
        tick(H);
        for (int i = 0; i < lead; i++) sbit(1'b0, so, oe);
        sbit(1'b1, so, oe);
        sbit(1'b1, so, oe);
        sbit(1'b0, so, oe);
        check("R9 oe low before dummy", 32'(oe), 0);
        for (int i = alen - 1; i >= 0; i--) sbit(a[i], so, oe);
        sbit(1'b0, so, oe);
        check("R7 dummy zero with oe", {so, oe}, 2'b01);
        ad = a;
        for (int k = 0; k < nw; k++) begin
            got = '0;
            for (int b = 0; b < dlen; b++) begin
                sbit(1'b0, so, oe);
                got = {got[14:0], so};
            end
            check(k == 0 ? "R7 read data" : "R8 sequential data", 32'(got), 32'(exp_word(ad, w)));
            ad = (ad + 1) % (w ? 64 : 128);
        end
        cs_i = 1'b0;
        tick(8);
        check("R9 oe after deselect", 32'(sdo_oe_o), 0);
        check("R5 read gives no strobe", 32'(cap_n), 32'(n0));
    endtask

    task automatic do_cmd(input logic w, input logic [1:0] op, input int a,
                          input logic [15:0] d, input int extra, input logic coinc);
        logic so, oe;
        int alen, dlen, k, n0, expc;
        logic hasdata;
        alen = w ? 6 : 7;
        dlen = w ? 16 : 8;
        k = exp_kind(op, a, w);
        hasdata = (k == 1) || (k == 4);
        n0 = cap_n;
        set_org(w);
        cs_i = 1'b1;
        tick(H);
        sbit(1'b1, so, oe);
        sbit(op[1], so, oe);
        sbit(op[0], so, oe);
        for (int i = alen - 1; i >= 0; i--) sbit(a[i], so, oe);
        if (hasdata) for (int i = dlen - 1; i >= 0; i--) sbit(d[i], so, oe);
        for (int i = 0; i < extra; i++) sbit(1'b0, so, oe);
        expc = 3 + alen + (hasdata ? dlen : 0) + extra;
        if (expc > 63) expc = 63;
        if (coinc) begin
            sdi_i = 1'b0;
            tick(H);
            sck_i = 1'b1;
            cs_i = 1'b0;
            tick(H);
            sck_i = 1'b0;
        end else begin
            cs_i = 1'b0;
        end
        tick(10);
        check("R5 one strobe", 32'(cap_n), 32'(n0 + 1));
        check("R3 kind", 32'(cap_kind), 32'(k));
        check("R4 address", 32'(cap_addr), 32'(a));
        if (hasdata) check("R4 data", 32'(cap_data), w ? 32'(d) : 32'(d[7:0]));
        check(coinc ? "R11 coincident pulse dropped" : "R6 pulse count", 32'(cap_clks), 32'(expc));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic so, oe;
        int n0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) bm[i] = 8'hFF;
        tick(3);
        rst_n = 1'b1;
        tick(4);
        check("R1 oe after reset", 32'(sdo_oe_o), 0);
        check("R1 strobe after reset", 32'(cmd_valid_o), 0);
        do_read(1'b0, 5, 1, 0);
        do_read(1'b1, 40, 2, 0);

        // R10 writes through the port, read back in both views
        mwrite(1'b0, 6, 16'h005A);
        mwrite(1'b1, 10, 16'hBEEF);
        do_read(1'b0, 20, 2, 0);
        do_read(1'b1, 3, 1, 0);

        // R8 wrap in both organisations
        mwrite(1'b0, 127, 16'h0033);
        mwrite(1'b0, 0, 16'h00C4);
        do_read(1'b0, 127, 2, 0);
        mwrite(1'b1, 63, 16'h1234);
        do_read(1'b1, 63, 2, 0);

        // R2 leading zeros before start bit
        do_read(1'b0, 6, 1, 3);

        // R3 R5 R6 directed commands
        do_cmd(1'b0, 2'b01, 7'h35, 16'h00A5, 0, 1'b0);
        do_cmd(1'b1, 2'b01, 7'h2A, 16'hC3E1, 0, 1'b0);
        do_cmd(1'b0, 2'b01, 7'h11, 16'h0077, 1, 1'b0);
        do_cmd(1'b0, 2'b11, 7'h44, 16'h0, 0, 1'b0);
        do_cmd(1'b0, 2'b00, 7'h60, 16'h0, 0, 1'b0);
        do_cmd(1'b1, 2'b00, 7'h30, 16'h0, 0, 1'b0);
        do_cmd(1'b0, 2'b00, 7'h40, 16'h0, 0, 1'b0);
        do_cmd(1'b1, 2'b00, 7'h10, 16'h9ABC, 0, 1'b0);
        do_cmd(1'b0, 2'b00, 7'h20, 16'h005E, 0, 1'b0);
        do_cmd(1'b1, 2'b00, 7'h01, 16'h0, 0, 1'b0);
        // R6 saturation
        do_cmd(1'b1, 2'b01, 7'h05, 16'h1111, 45, 1'b0);
        // R11 coincidence of select fall and clock rise
        do_cmd(1'b0, 2'b01, 7'h12, 16'h0081, 0, 1'b1);
        do_cmd(1'b1, 2'b11, 7'h07, 16'h0, 2, 1'b1);

        // R2 select rising while clock high: ignored entirely
        n0 = cap_n;
        set_org(1'b0);
        sck_i = 1'b1;
        tick(4);
        cs_i = 1'b1;
        tick(H);
        sck_i = 1'b0;
        tick(H);
        sbit(1'b1, so, oe);
        sbit(1'b1, so, oe);
        sbit(1'b0, so, oe);
        for (int i = 0; i < 12; i++) begin
            sbit(1'b0, so, oe);
            check("R2 ignored selection keeps oe low", 32'(oe), 0);
        end
        cs_i = 1'b0;
        tick(10);
        check("R2 ignored selection no strobe", 32'(cap_n), 32'(n0));

        // Random traffic
        for (int it = 0; it < 20; it++) begin
            logic w;
            logic [1:0] op;
            int a;
            w = 1'($urandom % 2);
            for (int j = 0; j < 2; j++)
                mwrite(w, int'($urandom % (w ? 64 : 128)), 16'($urandom));
            a = int'($urandom % (w ? 64 : 128));
            do_read(w, a, 1 + int'($urandom % 3), int'($urandom % 2));
            case ($urandom % 3)
                0: op = 2'b01;
                1: op = 2'b11;
                default: op = 2'b00;
            endcase
            do_cmd(w, op, int'($urandom % (w ? 64 : 128)), 16'($urandom),
                   int'($urandom % 3), 1'($urandom % 4 == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule